// File: doc/BRIEF.md
# Masked Multi-Lane Vector Execution Sequencer

This block carries out a single vector arithmetic instruction over a group of parallel lanes. After a start pulse it latches the opcode, the three register numbers and the vector length. It then walks through the vector one lane group per cycle. Element `e` lives in lane `e mod NLANES`, in row `e / NLANES` of that lane's slice of every vector register. Each lane holds its own bank of data words and the per-element condition flags for the elements it owns.

In every busy cycle each lane reads two source words and its flag bit and computes a result. It then either writes the destination word, writes its flag bit, or leaves its state alone. The choice depends on the opcode, the flag and whether its element index falls below the active length. The per-lane write strobes, the write data and the group number are brought out so that the surrounding datapath can follow the stores. A one-cycle done pulse closes the instruction.

Top module: `vseq_top`

## Requirements
- R1: After reset no strobe or done is raised and busy is low. Register `r`, element `e` holds `(29*r + 7*e + 5) mod 2^W`, and flag `e` is 1 exactly when `e mod 3` is not 0.
- R2: A start seen while idle produces `max(1, ceil(L/NLANES))` consecutive busy cycles beginning one cycle later, where `L` is the effective length. In busy cycle `g`, `grp` equals `g` and lane `l` handles element `g*NLANES + l`.
- R3: The effective length is `vlen` clamped to MVL. A length of 0 gives one busy cycle with no write of any kind.
- R4: No lane writes data or a flag for an element index at or above the effective length.
- R5: Opcodes 0 (add), 1 (subtract) and 2 (multiply) write `vs1 op vs2` modulo `2^W`, and only for elements whose flag is 1. Elements whose flag is 0 keep their earlier value.
- R6: Opcode 4 (merge) writes every active element, taking the `vs1` word where the flag is 1 and the `vs2` word where it is 0.
- R7: Opcode 3 (unsigned less-than) writes flag `e` with `vs1[e] < vs2[e]` for every active element. It raises `flag_we` with the bit on `lane_wdata` bit 0 and raises no `lane_we`.
- R8: Opcodes 5, 6 and 7 run the normal number of busy cycles but write nothing.
- R9: Done is high for exactly one cycle, the cycle right after the last busy cycle, and busy is low in that cycle.
- R10: A start raised while busy is ignored. The running instruction finishes unchanged and no extra instruction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opcode | input | 3 | Operation code |
| vd | input | clog2(NREGS) | Destination register number |
| vs1 | input | clog2(NREGS) | First source register number |
| vs2 | input | clog2(NREGS) | Second source register number |
| vlen | input | clog2(MVL+1) | Requested vector length |
| lane_we | output | NLANES | Per-lane data write strobe |
| flag_we | output | NLANES | Per-lane flag write strobe |
| lane_wdata | output | NLANES*W | Per-lane write value, lane `l` at bits `l*W +: W` |
| grp | output | clog2(MVL/NLANES) | Lane group being processed |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is proving that masked-off elements kept their old contents. The ports show only values being written, never values being held. The stimulus therefore runs a long chain of instructions whose destinations become later sources. Compare instructions keep reshaping the flag pattern along the way. A stale or wrongly overwritten word then shows up as a wrong result in a later add, merge or compare. Lengths are swept from 0 up past MVL under every opcode, which covers partial last groups and the clamp. A second start is injected during every multi-group instruction.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_SLT = 3'd3,
    OP_MRG = 3'd4
  } vop_e;
endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int NLANES = 4,
  parameter int MVL    = 16,
  parameter int NREGS  = 8,
  localparam int DEPTH = MVL / NLANES,
  localparam int GW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int EW    = $clog2(MVL + 1),
  localparam int RW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    opcode,
  input  logic [RW-1:0] vd,
  input  logic [RW-1:0] vs1,
  input  logic [RW-1:0] vs2,
  input  logic [EW-1:0] vlen,
  output logic          busy,
  output logic          done,
  output logic [GW-1:0] grp,
  output vop_e          op,
  output logic [RW-1:0] vd_q,
  output logic [RW-1:0] vs1_q,
  output logic [RW-1:0] vs2_q,
  output logic [EW-1:0] len_q
);
  logic          busy_q, busy_d, done_q, done_d, load;
  logic [GW-1:0] grp_q, grp_d;
  logic [EW:0]   next_base;
  logic [EW-1:0] len_clamp;
  logic          last;

  assign len_clamp = (vlen > EW'(MVL)) ? EW'(MVL) : vlen;
  assign next_base = (EW+1)'((32'(grp_q) + 1) * NLANES);
  assign last      = next_base >= {1'b0, len_q};

  always_comb begin
    busy_d = busy_q;
    grp_d  = grp_q;
    done_d = 1'b0;
    load   = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      grp_d  = '0;
      load   = 1'b1;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        grp_d = grp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      grp_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      grp_q  <= grp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op    <= OP_ADD;
      vd_q  <= '0;
      vs1_q <= '0;
      vs2_q <= '0;
      len_q <= '0;
    end else if (load) begin
      op    <= vop_e'(opcode);
      vd_q  <= vd;
      vs1_q <= vs1;
      vs2_q <= vs2;
      len_q <= len_clamp;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign grp  = grp_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(op) && $stable(len_q) && $stable(vd_q)));
  // R2
  grp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (grp_q == $past(grp_q) + 1'b1));
  // R3
  len_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (len_q <= EW'(MVL)));
endmodule

// File: rtl/vseq_lane.sv
module vseq_lane
  import vseq_pkg::*;
#(
  parameter int LANE   = 0,
  parameter int NLANES = 4,
  parameter int MVL    = 16,
  parameter int NREGS  = 8,
  parameter int W      = 16,
  localparam int DEPTH = MVL / NLANES,
  localparam int GW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int EW    = $clog2(MVL + 1),
  localparam int RW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [GW-1:0] grp,
  input  logic [EW-1:0] len,
  input  vop_e          op,
  input  logic [RW-1:0] vd,
  input  logic [RW-1:0] vs1,
  input  logic [RW-1:0] vs2,
  output logic          we,
  output logic          fwe,
  output logic [W-1:0]  wdata
);
  logic [W-1:0]     mem [NREGS][DEPTH];
  logic [DEPTH-1:0] flg;
  logic [EW-1:0]    eidx;
  logic             act, f;
  logic [W-1:0]     a, b;

  assign eidx = EW'(grp) * EW'(NLANES) + EW'(LANE);
  assign act  = busy && (eidx < len);
  assign a    = mem[vs1][grp];
  assign b    = mem[vs2][grp];
  assign f    = flg[grp];

  always_comb begin
    we    = 1'b0;
    fwe   = 1'b0;
    wdata = '0;
    case (op)
      OP_ADD: begin we = act && f; wdata = a + b; end
      OP_SUB: begin we = act && f; wdata = a - b; end
      OP_MUL: begin we = act && f; wdata = a * b; end
      OP_MRG: begin we = act; wdata = f ? a : b; end
      OP_SLT: begin fwe = act; wdata = W'(a < b); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++)
        for (int d = 0; d < DEPTH; d++)
          mem[r][d] <= W'(r * 29 + (d * NLANES + LANE) * 7 + 5);
      for (int d = 0; d < DEPTH; d++)
        flg[d] <= ((d * NLANES + LANE) % 3) != 0;
    end else begin
      if (we)  mem[vd][grp] <= wdata;
      if (fwe) flg[grp]     <= wdata[0];
    end
  end

  // R7
  cmp_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwe |-> !we);
endmodule

// File: rtl/vseq_top.sv
module vseq_top
  import vseq_pkg::*;
#(
  parameter int NLANES = 4,
  parameter int MVL    = 16,
  parameter int NREGS  = 8,
  parameter int W      = 16,
  localparam int DEPTH = MVL / NLANES,
  localparam int GW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int EW    = $clog2(MVL + 1),
  localparam int RW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        opcode,
  input  logic [RW-1:0]     vd,
  input  logic [RW-1:0]     vs1,
  input  logic [RW-1:0]     vs2,
  input  logic [EW-1:0]     vlen,
  output logic [NLANES-1:0] lane_we,
  output logic [NLANES-1:0] flag_we,
  output logic [NLANES*W-1:0] lane_wdata,
  output logic [GW-1:0]     grp,
  output logic              busy,
  output logic              done
);
  vop_e          op;
  logic [RW-1:0] vd_q, vs1_q, vs2_q;
  logic [EW-1:0] len_q;

  vseq_ctrl #(.NLANES(NLANES), .MVL(MVL), .NREGS(NREGS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .vd(vd), .vs1(vs1), .vs2(vs2), .vlen(vlen),
    .busy(busy), .done(done), .grp(grp), .op(op),
    .vd_q(vd_q), .vs1_q(vs1_q), .vs2_q(vs2_q), .len_q(len_q)
  );

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    vseq_lane #(.LANE(l), .NLANES(NLANES), .MVL(MVL), .NREGS(NREGS), .W(W)) u_lane (
      .clk(clk), .rst_n(rst_n), .busy(busy), .grp(grp), .len(len_q), .op(op),
      .vd(vd_q), .vs1(vs1_q), .vs2(vs2_q),
      .we(lane_we[l]), .fwe(flag_we[l]), .wdata(lane_wdata[l*W +: W])
    );

    // R4
    wr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_we[l] || flag_we[l]) |-> ((32'(grp) * NLANES + l) < 32'(len_q)));
  end

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we || |flag_we) |-> busy);
endmodule

// File: tb/tb_vseq_top.sv
`timescale 1ns/1ps
module tb_vseq_top;
  localparam int N = 4, MVL = 16, NR = 8, W = 16;

  logic clk, rst_n, start;
  logic [2:0] opcode, vd, vs1, vs2;
  logic [4:0] vlen;
  logic [N-1:0] lane_we, flag_we;
  logic [N*W-1:0] lane_wdata;
  logic [1:0] grp;
  logic busy, done;

  int checks = 0, fails = 0;
  logic [W-1:0] mdl [NR][MVL];
  bit mflg [MVL];

  vseq_top #(.NLANES(N), .MVL(MVL), .NREGS(NR), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .vd(vd),
    .vs1(vs1), .vs2(vs2), .vlen(vlen), .lane_we(lane_we), .flag_we(flag_we),
    .lane_wdata(lane_wdata), .grp(grp), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int op, input int d, input int s1, input int s2, input int len);
    int clen, ng;
    clen = (len > MVL) ? MVL : len;
    ng = (clen == 0) ? 1 : (clen + N - 1) / N;
    start = 1'b1; opcode = 3'(op); vd = 3'(d); vs1 = 3'(s1); vs2 = 3'(s2); vlen = 5'(len);
    @(negedge clk);
    start = 1'b0;
    for (int g = 0; g < ng; g++) begin
      logic [N-1:0] ewe, efwe;
      logic [W-1:0] ed [N];
      ewe = '0; efwe = '0;
      for (int l = 0; l < N; l++) begin
        int e;
        logic [W-1:0] a, b;
        e = g * N + l;
        a = mdl[s1][e]; b = mdl[s2][e];
        ed[l] = '0;
        if (e < clen) begin
          case (op)
            0: begin ewe[l] = mflg[e]; ed[l] = a + b; end   // R5
            1: begin ewe[l] = mflg[e]; ed[l] = a - b; end   // R5
            2: begin ewe[l] = mflg[e]; ed[l] = a * b; end   // R5
            3: begin efwe[l] = 1'b1; ed[l] = W'(a < b); end // R7
            4: begin ewe[l] = 1'b1; ed[l] = mflg[e] ? a : b; end // R6
            default: ;                                      // R8
          endcase
        end
      end
      chk(busy == 1'b1, "R2", "busy", busy, 1);
      chk(grp == 2'(g), "R2", "grp", grp, g);
      chk(done == 1'b0, "R9", "done early", done, 0);
      chk(lane_we == ewe, "R4", "lane_we", lane_we, ewe);
      chk(flag_we == efwe, "R7", "flag_we", flag_we, efwe);
      for (int l = 0; l < N; l++)
        if (ewe[l] || efwe[l])
          chk(lane_wdata[l*W +: W] == ed[l], "R5", "wdata", lane_wdata[l*W +: W], ed[l]);
      for (int l = 0; l < N; l++) begin
        if (ewe[l]) mdl[d][g*N+l] = ed[l];
        if (efwe[l]) mflg[g*N+l] = ed[l][0];
      end
      // R10: raise a foreign start during the first group of a long instruction
      if (g == 0 && ng >= 2) begin
        start = 1'b1; opcode = 3'(4); vd = 3'(d + 1); vlen = 5'd16;
      end
      if (g == 1) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1, "R9", "done", done, 1);
    chk(busy == 1'b0, "R10", "busy after end", busy, 0);
    chk(lane_we == '0 && flag_we == '0, "R3", "strobes at done", lane_we, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", done, 0);
    chk(busy == 1'b0, "R10", "no extra run", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++)
      for (int e = 0; e < MVL; e++) mdl[r][e] = W'(r * 29 + e * 7 + 5);  // R1
    for (int e = 0; e < MVL; e++) mflg[e] = (e % 3) != 0;
    rst_n = 1'b0; start = 1'b0; opcode = '0; vd = '0; vs1 = '0; vs2 = '0; vlen = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lane_we == '0 && flag_we == '0, "R1", "reset strobes", lane_we, 0);
    chk(done == 1'b0 && busy == 1'b0, "R1", "reset busy/done", busy, 0);
    // R1: reset contents observed through a full-length merge into r7
    run(4, 7, 1, 2, 16);
    // R3: zero length and over-long requests
    run(0, 3, 1, 1, 0);
    run(0, 4, 2, 5, 20);
    for (int len = 0; len <= 17; len++)
      for (int op = 0; op < 8; op++) begin
        int i;
        i = len * 8 + op;
        run(op, (i * 3) % NR, (i * 5 + 1) % NR, (i + 2) % NR, len);
      end
    // R5: read back every register through a merge with equal sources
    for (int r = 0; r < NR; r++) run(4, (r + 1) % NR, r, r, 16);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule